// File: doc/BRIEF.md
# Receive FIFO with Character Timeout

This block is the receive side storage of a 16550-class serial port. Bytes recovered by an external deserialiser arrive with a one-cycle valid strobe and are queued in a parameterised first-in first-out store, 16 entries by default. The host drains the queue with a read strobe; the popped byte appears on `rd_data` one cycle later. A line break arrives on its own strobe and is queued as a zero byte. When the store is full, new arrivals are discarded and an overrun flag is raised. Stored bytes are never overwritten.

A configuration write carries the FIFO control byte. Bit 0 enables queued operation, bit 1 requests a flush, and bits 7:6 choose the trigger level. A frame format input, in the usual line-control layout, sets the length of one character in bit times. Bit-time pulses come from an external baud divider. If bytes sit in the queue and nothing is received or read for four character times, a timeout-pending flag rises so the host can collect a partial batch. With queuing disabled, the block falls back to a single holding register.

Top module: `rx_fifo_timeout`

## Requirements
- R1: After reset the queue is empty and `fill_count` is 0. `data_ready`, `brk_flag`, `ovr_flag`, `trig_hit` and `tmo_pending` are 0, `rd_data` is 0, and queuing is disabled.
- R2: While queuing is enabled, `trig_hit` is 1 exactly when `fill_count` is at least the trigger level. Configuration bits 7:6 select that level: code 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. While queuing is disabled, `trig_hit` is 0.
- R3: A byte that arrives while the queue holds DEPTH entries is discarded and `ovr_flag` is set. `fill_count` stays at DEPTH, and the bytes already stored are later read out unchanged and in order.
- R4: A break strobe queues a zero byte and sets both `brk_flag` and `data_ready`.
- R5: `tmo_pending` rises when the queue is non-empty and four character times of bit pulses pass with no receive and no read. A receive restarts the count, and so does a read that leaves data behind.
- R6: One character time, in bit pulses, is 1 start bit, plus `frame_fmt[1:0]`+5 data bits, plus 1 if `frame_fmt[3]` is set, plus 2 stop bits if `frame_fmt[2]` is set or 1 if it is clear.
- R7: Bytes are read out in arrival order, with `rd_data` valid the cycle after the read strobe. A read of an empty queue returns 0. A read that empties the queue clears `data_ready` and `brk_flag`. Every read clears `tmo_pending`.
- R8: A configuration write flushes the queue, clearing `fill_count`, `data_ready`, `brk_flag` and `tmo_pending`, when bit 1 is set or when bit 0 differs from the current enable. Any other configuration write leaves the stored data intact.
- R9: With queuing disabled, each arrival replaces a single holding register and sets `data_ready`. An arrival while `data_ready` is already set raises `ovr_flag`. A read returns the held byte and clears `data_ready` and `brk_flag`, and `fill_count` stays 0.
- R10: A line status read strobe clears `ovr_flag` and `brk_flag` and leaves `data_ready` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | WIDTH | Received byte |
| rx_break | input | 1 | One-cycle strobe: a line break was detected |
| rd_pop | input | 1 | Host read strobe for the receive data |
| ls_read | input | 1 | Host read strobe for the line status |
| cfg_wr | input | 1 | FIFO control write strobe |
| cfg_data | input | 8 | FIFO control byte (bit 0 enable, bit 1 flush, bits 7:6 trigger code) |
| frame_fmt | input | 4 | Frame format: [1:0] data length, [2] stop bits, [3] parity present |
| bit_tick | input | 1 | One pulse per serial bit time |
| rd_data | output | WIDTH | Byte returned by the last read |
| data_ready | output | 1 | Data available |
| brk_flag | output | 1 | Break received |
| ovr_flag | output | 1 | Overrun occurred |
| fill_count | output | CW | Number of queued bytes |
| trig_hit | output | 1 | Fill level reached the trigger level |
| tmo_pending | output | 1 | Character timeout pending |

## Verification
The embedded properties assume every strobe is a single-cycle pulse. They also assume a configuration write is never issued in the same cycle as a receive or a read, because a flush would otherwise override the arrival being checked. The stimulus drives each strobe alone, for one cycle between falling edges, with `bit_tick` pulsed separately. As a result, no two events compete within a cycle and every property sees the isolated case it describes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Trigger threshold selected by the two-bit control code.
  function automatic logic [3:0] trig_level(input logic [1:0] code);
    case (code)
      2'b00:   trig_level = 4'd1;
      2'b01:   trig_level = 4'd4;
      2'b10:   trig_level = 4'd8;
      default: trig_level = 4'd14;
    endcase
  endfunction

  // Bit times in one character: start + data + optional parity + stop.
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    frame_bits = 4'd7 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + {3'b000, fmt[2]};
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  // Storage without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: the controller must never push into a full store without a pop.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr) |-> (count < CW'(DEPTH)));

  // R7: a pop is only issued while data is stored.
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (pop && !clr) |-> (count != '0));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int TMO_CHARS = 4,
  localparam int TW = $clog2(TMO_CHARS * 12 + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [3:0] fmt,
  input  logic       active,
  input  logic       restart,
  input  logic       clear,
  output logic       pending
);

  import rxq_pkg::*;

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit = TW'(TMO_CHARS) * TW'(frame_bits(fmt));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (restart || !active) begin
      cnt <= '0;
    end else if (tick && !pending) begin
      if (cnt == limit - 1'b1) pending <= 1'b1;
      else                     cnt     <= cnt + 1'b1;
    end
  end

  // R5: pending only exists while there is queued data to report.
  a_r5_pending_needs_data: assert property (@(posedge clk) disable iff (rst)
    pending |-> active);

  // R5: pending is only raised by a bit pulse.
  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(tick));

endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout #(
  parameter int DEPTH     = 16,
  parameter int WIDTH     = 8,
  parameter int TMO_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [WIDTH-1:0] rx_byte,
  input  logic             rx_break,
  input  logic             rd_pop,
  input  logic             ls_read,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_data,
  input  logic [3:0]       frame_fmt,
  input  logic             bit_tick,
  output logic [WIDTH-1:0] rd_data,
  output logic             data_ready,
  output logic             brk_flag,
  output logic             ovr_flag,
  output logic [CW-1:0]    fill_count,
  output logic             trig_hit,
  output logic             tmo_pending
);

  import rxq_pkg::*;

  logic             fifo_en;
  logic [1:0]       trig_code;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] head;
  logic [CW-1:0]    count;
  logic             flush, rx_evt, q_full, q_empty;
  logic             do_push, do_pop, drop, empties;
  logic [WIDTH-1:0] rx_val;
  logic             unused_cfg;

  assign unused_cfg = ^cfg_data[5:2];

  assign flush   = cfg_wr && (cfg_data[1] || (cfg_data[0] != fifo_en));
  assign rx_evt  = rx_valid || rx_break;
  assign rx_val  = rx_break ? '0 : rx_byte;
  assign q_full  = (count == CW'(DEPTH));
  assign q_empty = (count == '0);
  assign do_pop  = fifo_en && rd_pop && !q_empty && !flush;
  assign do_push = fifo_en && rx_evt && !flush && (!q_full || do_pop);
  assign drop    = fifo_en && rx_evt && !flush && q_full && !do_pop;
  assign empties = do_pop && (count == CW'(1)) && !do_push;

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush),
    .push  (do_push),
    .pop   (do_pop),
    .din   (rx_val),
    .head  (head),
    .count (count)
  );

  rxq_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (bit_tick),
    .fmt     (frame_fmt),
    .active  (fifo_en && !q_empty),
    .restart (fifo_en && rx_evt && !flush),
    .clear   (flush || rd_pop),
    .pending (tmo_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en    <= 1'b0;
      trig_code  <= 2'b00;
      hold_q     <= '0;
      rd_data    <= '0;
      data_ready <= 1'b0;
      brk_flag   <= 1'b0;
      ovr_flag   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        fifo_en   <= cfg_data[0];
        trig_code <= cfg_data[7:6];
      end

      if (rd_pop) rd_data <= fifo_en ? (q_empty ? '0 : head) : hold_q;

      if (!fifo_en && rx_evt && !flush) hold_q <= rx_val;

      // Clears first, then sets, so a same-cycle arrival wins.
      if (ls_read) ovr_flag <= 1'b0;
      if (drop || (!fifo_en && rx_evt && data_ready && !flush)) ovr_flag <= 1'b1;

      if (ls_read || flush || empties || (!fifo_en && rd_pop)) brk_flag <= 1'b0;
      if (rx_break && !flush) brk_flag <= 1'b1;

      if (flush || empties || (!fifo_en && rd_pop)) data_ready <= 1'b0;
      if (do_push || (!fifo_en && rx_evt && !flush)) data_ready <= 1'b1;
    end
  end

  assign fill_count = count;
  assign trig_hit   = fifo_en && (count >= CW'(trig_level(trig_code)));

  // R3: a byte arriving at a full queue is dropped with overrun.
  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && q_full && rx_valid && !rd_pop && !cfg_wr) |=>
      (ovr_flag && fill_count == CW'(DEPTH)));

  // R4: break raises both break and data-ready.
  a_r4_break_flags: assert property (@(posedge clk) disable iff (rst)
    (rx_break && !cfg_wr) |=> (brk_flag && data_ready));

  // R7: any read drops the timeout indication.
  a_r7_read_clears_pending: assert property (@(posedge clk) disable iff (rst)
    rd_pop |=> !tmo_pending);

  // R8: a flush request leaves nothing queued or flagged.
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_data[1]) |=> (fill_count == '0 && !data_ready && !tmo_pending));

  // R9: holding-register mode overrun on unread data.
  a_r9_hold_overrun: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && rx_valid && data_ready && !cfg_wr) |=> ovr_flag);

endmodule

// File: tb/rx_fifo_timeout_test.sv
`timescale 1ns/1ps
module rx_fifo_timeout_test;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rx_valid = 1'b0, rx_break = 1'b0, rd_pop = 1'b0, ls_read = 1'b0;
  logic            cfg_wr = 1'b0, bit_tick = 1'b0;
  logic [7:0]      rx_byte = '0, cfg_data = '0;
  logic [3:0]      frame_fmt = '0;
  logic [7:0]      rd_data;
  logic            data_ready, brk_flag, ovr_flag, trig_hit, tmo_pending;
  logic [CW-1:0]   fill_count;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rx_fifo_timeout #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_break(rx_break), .rd_pop(rd_pop), .ls_read(ls_read),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .frame_fmt(frame_fmt),
    .bit_tick(bit_tick), .rd_data(rd_data), .data_ready(data_ready),
    .brk_flag(brk_flag), .ovr_flag(ovr_flag), .fill_count(fill_count),
    .trig_hit(trig_hit), .tmo_pending(tmo_pending)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0; d = rd_data;
  endtask

  task automatic lsr();
    @(negedge clk); ls_read = 1'b1;
    @(negedge clk); ls_read = 1'b0;
  endtask

  task automatic fcr(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 fill", fill_count, 0);
    chk("R1 flags", {data_ready, brk_flag, ovr_flag, trig_hit, tmo_pending}, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    logic [7:0] d;
    fcr(8'h01);
    rx(8'h5A); rx(8'hA5); rx(8'h3C);
    chk("R7 fill after 3", fill_count, 3);
    chk("R7 data_ready", data_ready, 1);
    pop(d); chk("R7 first", d, 8'h5A);
    pop(d); chk("R7 second", d, 8'hA5);
    pop(d); chk("R7 third", d, 8'h3C);
    chk("R7 dr cleared on empty", data_ready, 0);
    pop(d); chk("R7 empty read", d, 0);
  endtask

  task automatic t_trigger();
    int lv [4] = '{1, 4, 8, 14};
    for (int c = 0; c < 4; c++) begin
      fcr({c[1:0], 6'b000011});
      for (int i = 0; i < lv[c] - 1; i++) rx(8'(i));
      if (lv[c] > 1) chk("R2 below level", trig_hit, 0);
      rx(8'hFF);
      chk("R2 at level", trig_hit, 1);
    end
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    fcr(8'h03);
    for (int i = 0; i < DEPTH; i++) rx(8'h40 + 8'(i));
    chk("R3 full count", fill_count, DEPTH);
    chk("R3 no ovr yet", ovr_flag, 0);
    rx(8'hEE);
    chk("R3 ovr set", ovr_flag, 1);
    chk("R3 count kept", fill_count, DEPTH);
    lsr();
    chk("R10 ovr cleared", ovr_flag, 0);
    chk("R10 dr kept", data_ready, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d); chk("R3 content", d, 8'h40 + i);
    end
  endtask

  task automatic t_break();
    logic [7:0] d;
    fcr(8'h03);
    brk();
    chk("R4 fill", fill_count, 1);
    chk("R4 brk+dr", {brk_flag, data_ready}, 2'b11);
    lsr();
    chk("R10 brk cleared", {brk_flag, data_ready}, 2'b01);
    brk();
    pop(d); chk("R4 zero byte", d, 0);
    chk("R7 brk kept (not empty)", brk_flag, 1);
    pop(d); chk("R4 zero byte 2", d, 0);
    chk("R7 empty clears brk+dr", {brk_flag, data_ready}, 0);
  endtask

  task automatic t_flush();
    fcr(8'h03);
    rx(8'h11); rx(8'h22);
    fcr(8'h01);
    chk("R8 plain write keeps", fill_count, 2);
    fcr(8'h03);
    chk("R8 flush bit", {fill_count, data_ready}, 0);
    rx(8'h33);
    fcr(8'h00);
    chk("R8 toggle flush", {fill_count, data_ready}, 0);
    chk("R2 disabled trig", trig_hit, 0);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    frame_fmt = 4'h0;
    fcr(8'h03);
    rx(8'hA1); rx(8'hA2);
    ticks(20);
    pop(d);
    ticks(27);
    chk("R5 not yet (read restart)", tmo_pending, 0);
    ticks(1);
    chk("R5 pending after 28", tmo_pending, 1);
    pop(d);
    chk("R7 read clears pending", tmo_pending, 0);
    rx(8'hB1);
    ticks(20);
    rx(8'hB2);
    ticks(27);
    chk("R5 not yet (rx restart)", tmo_pending, 0);
    ticks(1);
    chk("R5 pending after rx restart", tmo_pending, 1);
    frame_fmt = 4'hF;
    fcr(8'h03);
    chk("R8 flush clears pending", tmo_pending, 0);
    rx(8'hC1);
    ticks(47);
    chk("R6 12-bit frame not yet", tmo_pending, 0);
    ticks(1);
    chk("R6 12-bit frame pending", tmo_pending, 1);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    fcr(8'h00);
    rx(8'h11);
    chk("R9 dr", data_ready, 1);
    chk("R9 fill stays 0", fill_count, 0);
    chk("R9 no ovr", ovr_flag, 0);
    pop(d); chk("R9 read", d, 8'h11);
    chk("R9 dr cleared", data_ready, 0);
    rx(8'h22); rx(8'h33);
    chk("R9 ovr", ovr_flag, 1);
    pop(d); chk("R9 newest kept", d, 8'h33);
    lsr();
    chk("R10 ovr cleared", ovr_flag, 0);
    brk();
    chk("R9 break flags", {brk_flag, data_ready}, 2'b11);
    pop(d); chk("R9 break byte", d, 0);
    chk("R9 read clears brk", brk_flag, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_overrun();
    t_break();
    t_flush();
    t_timeout();
    t_disabled();
    finish_run();
  end

endmodule